// File: doc/BRIEF.md
# Serial-Programmed Clock Fanout Enable Controller

This block owns the enable state for a bank of ten fanout clock outputs. A two-wire bus master writes it, and the block cannot be read back. The bus lines SCL and SDA are sampled as plain inputs on the system clock. The block acknowledges a byte by asserting a pull-low request for an open-drain SDA pad. It recognises start and stop conditions and responds only to write address 0xD2. It accepts and discards two header bytes, then stores data bytes strictly in arrival order, beginning at register byte 0. No register pointer exists, so a master that wants to change a later byte must resend every byte before it.

Each of the ten outputs copies a single reference clock while its enable bit is set and sits low while it is clear. A new enable value moves into the reference clock domain and takes effect only during a low phase of that clock, so no output pulse is ever shortened. An active-low output-enable pin drops the pad drive enables of all ten outputs at once, which lets board test float the clock nets.

Top module: `clkfan_ctrl`

## Requirements
- R1: After reset, all three register bytes hold their power-up values: byte 0 = 0xFF, byte 1 = 0xFF, byte 2 = 0xC3. As a result all ten outputs follow `ref_clk`, and `sda_pull` is 0.
- R2: A first byte of 0xD2 (write address, MSB first) is acknowledged: `sda_pull` is 1 while SCL is high in the ninth clock. `sda_pull` only turns on or off while SCL is low.
- R3: Any other first byte, 0xD3 included, gets no acknowledge. Every later byte up to the next start also gets no acknowledge, and no enable changes.
- R4: The two bytes after the address are acknowledged, and their values have no effect on any output.
- R5: Data bytes 1, 2 and 3 after the header land in register bytes 0, 1 and 2 in that order. Byte 0 bits 3..0 drive outputs 3..0. Byte 1 bits 7..4 drive outputs 9..6. Byte 2 bit 6 drives output 4 and bit 7 drives output 5.
- R6: An output whose enable bit is 1 is high exactly while `ref_clk` is high. An output whose enable bit is 0 stays low.
- R7: Register bytes keep their values across transfers. A transfer that carries fewer data bytes leaves the bytes it does not reach unchanged.
- R8: Data bytes 4 to 10 are acknowledged and dropped. The 11th data byte and every byte after it get no acknowledge.
- R9: A start condition in the middle of a byte aborts that byte. The next byte is then taken as an address.
- R10: While `oe_n` is 0, `clk_drv_en` is all zeros. While `oe_n` is 1, it is all ones. Register contents do not affect it.
- R11: A stop condition ends the transfer and clears `sda_pull`. A byte clocked after a stop with no new start is not acknowledged and changes nothing.
- R12: An enable change takes effect only while `ref_clk` is low, so every output holds one constant level through each high phase of `ref_clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus lines |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_pull | output | 1 | 1 = pull the open-drain data line low |
| ref_clk | input | 1 | Reference clock copied to the outputs |
| oe_n | input | 1 | Active-low drive enable for all outputs |
| clk_out | output | 10 | Gated copies of `ref_clk` |
| clk_drv_en | output | 10 | Per-output pad drive enable, 0 = high impedance |

## Verification
The risky overlap is an enable write that comes out of the serial receiver while the reference clock is high. The gate must hold the new value back to the next low phase. The reference clock period is not a multiple of the bus bit time, so directed and random transfers land their writes in both phases. A monitor samples every output early and late in each high phase and requires the two samples to match. It also requires every output to be low in each low phase. A second overlap is a start condition arriving mid-byte. It is provoked by cutting a data byte after four bits, and it is judged by the acknowledge on the following address byte and by the register contents afterwards.

// File: rtl/clkfan_pkg.sv
package clkfan_pkg;

    localparam int unsigned CLK_LANES = 10;
    localparam int unsigned REG_BYTES = 3;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_SHIFT,
        RX_ACK,
        RX_SKIP
    } rx_state_e;

    // events decoded from the synchronised bus lines
    typedef struct packed {
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;

    // one register byte write toward the enable store
    typedef struct packed {
        logic       valid;
        logic [7:0] idx;
        logic [7:0] data;
    } wr_req_t;

    // register byte that holds the enable of a lane
    function automatic int unsigned lane_byte(int unsigned lane);
        if (lane < 4)      return 0;
        else if (lane < 6) return 2;
        else               return 1;
    endfunction

    // bit position of a lane's enable inside its register byte
    function automatic int unsigned lane_bit(int unsigned lane);
        if (lane < 4)      return lane;
        else if (lane < 6) return lane + 2;
        else               return lane - 2;
    endfunction

    function automatic logic [7:0] reg_reset_byte(int unsigned idx);
        if (idx == 2) return 8'hC3;
        else          return 8'hFF;
    endfunction

    function automatic logic lane_reset(int unsigned lane);
        logic [7:0] b;
        b = reg_reset_byte(lane_byte(lane));
        return b[lane_bit(lane)];
    endfunction

    function automatic logic [CLK_LANES-1:0] reset_enables();
        logic [CLK_LANES-1:0] v;
        for (int unsigned i = 0; i < CLK_LANES; i++) v[i] = lane_reset(i);
        return v;
    endfunction

endpackage

// File: rtl/clkfan_pin_sync.sv
module clkfan_pin_sync
    import clkfan_pkg::*;
#(
    parameter int unsigned STAGES = 2
)(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_in,
    input  logic     sda_in,
    output bus_evt_t evt
);
    logic [STAGES-1:0] scl_q;
    logic [STAGES-1:0] sda_q;
    logic              scl_d;
    logic              sda_d;
    logic              scl_s;
    logic              sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_q <= {scl_q[STAGES-2:0], scl_in};
            sda_q <= {sda_q[STAGES-2:0], sda_in};
            scl_d <= scl_q[STAGES-1];
            sda_d <= sda_q[STAGES-1];
        end
    end

    assign scl_s = scl_q[STAGES-1];
    assign sda_s = sda_q[STAGES-1];

    always_comb begin
        evt.sda      = sda_s;
        evt.scl_rise = scl_s & ~scl_d;
        evt.scl_fall = ~scl_s & scl_d;
        evt.start    = scl_s & scl_d & sda_d & ~sda_s;
        evt.stop     = scl_s & scl_d & ~sda_d & sda_s;
    end

endmodule

// File: rtl/clkfan_serial_rx.sv
module clkfan_serial_rx
    import clkfan_pkg::*;
#(
    parameter logic [7:0]  DEV_ADDR  = 8'hD2,
    parameter int unsigned HDR_BYTES = 2,
    parameter int unsigned MAX_DATA  = 10,
    parameter int unsigned NUM_REGS  = REG_BYTES
)(
    input  logic     clk,
    input  logic     rst,
    input  bus_evt_t evt,
    output logic     sda_pull,
    output wr_req_t  wr
);
    // byte number (address = 0) of the last byte that still gets an acknowledge
    localparam int unsigned LAST_ACK = HDR_BYTES + MAX_DATA;
    localparam int unsigned CNT_W    = $clog2(LAST_ACK + 2);

    rx_state_e        state;
    logic [3:0]       bit_cnt;
    logic [7:0]       shreg;
    logic [CNT_W-1:0] byte_cnt;
    logic             byte_full;
    logic             accept;
    logic             is_store;
    logic [7:0]       store_idx;
    int               data_pos;

    always_comb begin
        byte_full = (bit_cnt == 4'd8);
        data_pos  = int'(byte_cnt) - int'(HDR_BYTES) - 1;
        store_idx = 8'(data_pos);
        is_store  = 1'b0;
        if (byte_cnt == '0) begin
            accept = (shreg == DEV_ADDR);
        end else if (int'(byte_cnt) <= int'(HDR_BYTES)) begin
            accept = 1'b1;
        end else begin
            accept   = (int'(byte_cnt) <= int'(LAST_ACK));
            is_store = accept && (data_pos < int'(NUM_REGS));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= RX_IDLE;
            bit_cnt  <= '0;
            shreg    <= '0;
            byte_cnt <= '0;
            sda_pull <= 1'b0;
            wr       <= '0;
        end else begin
            wr.valid <= 1'b0;
            if (evt.start) begin
                state    <= RX_SHIFT;
                bit_cnt  <= '0;
                byte_cnt <= '0;
                sda_pull <= 1'b0;
            end else if (evt.stop) begin
                state    <= RX_IDLE;
                sda_pull <= 1'b0;
            end else begin
                unique case (state)
                    RX_SHIFT: begin
                        if (evt.scl_rise && !byte_full) begin
                            shreg   <= {shreg[6:0], evt.sda};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (evt.scl_fall && byte_full) begin
                            if (accept) begin
                                state    <= RX_ACK;
                                sda_pull <= 1'b1;
                                if (is_store) begin
                                    wr.valid <= 1'b1;
                                    wr.idx   <= store_idx;
                                    wr.data  <= shreg;
                                end
                            end else begin
                                state <= RX_SKIP;
                            end
                        end
                    end
                    RX_ACK: begin
                        if (evt.scl_fall) begin
                            state    <= RX_SHIFT;
                            sda_pull <= 1'b0;
                            bit_cnt  <= '0;
                            byte_cnt <= byte_cnt + 1'b1;
                        end
                    end
                    default: begin
                        state <= state;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/clkfan_enable_regs.sv
module clkfan_enable_regs
    import clkfan_pkg::*;
#(
    parameter int unsigned NUM_CLK = CLK_LANES
)(
    input  logic               clk,
    input  logic               rst,
    input  wr_req_t            wr,
    output logic [NUM_CLK-1:0] en_bits
);
    for (genvar g = 0; g < NUM_CLK; g++) begin : g_bit
        localparam logic [7:0]  SEL_BYTE = 8'(lane_byte(g));
        localparam int unsigned SEL_BIT  = lane_bit(g);
        localparam logic        RST_VAL  = lane_reset(g);

        always_ff @(posedge clk) begin
            if (rst) begin
                en_bits[g] <= RST_VAL;
            end else if (wr.valid && wr.idx == SEL_BYTE) begin
                en_bits[g] <= wr.data[SEL_BIT];
            end
        end
    end

endmodule

// File: rtl/clkfan_lane_gate.sv
module clkfan_lane_gate
    import clkfan_pkg::*;
#(
    parameter int unsigned NUM_CLK     = CLK_LANES,
    parameter int unsigned SYNC_STAGES = 2
)(
    input  logic               ref_clk,
    input  logic               rst,
    input  logic [NUM_CLK-1:0] en_async,
    input  logic               oe_n,
    output logic [NUM_CLK-1:0] clk_out,
    output logic [NUM_CLK-1:0] clk_drv_en
);
    localparam logic [CLK_LANES-1:0] RST_EN = reset_enables();

    for (genvar g = 0; g < NUM_CLK; g++) begin : g_lane
        logic [SYNC_STAGES-1:0] sq;
        logic                   hold;

        always_ff @(posedge ref_clk) begin
            if (rst) sq <= {SYNC_STAGES{RST_EN[g]}};
            else     sq <= {sq[SYNC_STAGES-2:0], en_async[g]};
        end

        // enable moves only on the falling edge: output is low at that moment
        always_ff @(negedge ref_clk) begin
            if (rst) hold <= RST_EN[g];
            else     hold <= sq[SYNC_STAGES-1];
        end

        assign clk_out[g] = ref_clk & hold;
    end

    assign clk_drv_en = {NUM_CLK{oe_n}};

endmodule

// File: rtl/clkfan_ctrl.sv
module clkfan_ctrl
    import clkfan_pkg::*;
#(
    parameter logic [7:0]  DEV_ADDR    = 8'hD2,
    parameter int unsigned HDR_BYTES   = 2,
    parameter int unsigned MAX_DATA    = 10,
    parameter int unsigned NUM_REGS    = REG_BYTES,
    parameter int unsigned NUM_CLK     = CLK_LANES,
    parameter int unsigned SYNC_STAGES = 2
)(
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_in,
    input  logic               sda_in,
    output logic               sda_pull,
    input  logic               ref_clk,
    input  logic               oe_n,
    output logic [NUM_CLK-1:0] clk_out,
    output logic [NUM_CLK-1:0] clk_drv_en
);
    bus_evt_t           evt;
    wr_req_t            wr;
    logic [NUM_CLK-1:0] en_bits;

    clkfan_pin_sync #(
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .evt    (evt)
    );

    clkfan_serial_rx #(
        .DEV_ADDR  (DEV_ADDR),
        .HDR_BYTES (HDR_BYTES),
        .MAX_DATA  (MAX_DATA),
        .NUM_REGS  (NUM_REGS)
    ) i_rx (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .sda_pull (sda_pull),
        .wr       (wr)
    );

    clkfan_enable_regs #(
        .NUM_CLK (NUM_CLK)
    ) i_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr),
        .en_bits (en_bits)
    );

    clkfan_lane_gate #(
        .NUM_CLK     (NUM_CLK),
        .SYNC_STAGES (SYNC_STAGES)
    ) i_gate (
        .ref_clk    (ref_clk),
        .rst        (rst),
        .en_async   (en_bits),
        .oe_n       (oe_n),
        .clk_out    (clk_out),
        .clk_drv_en (clk_drv_en)
    );

endmodule

// File: rtl/clkfan_ctrl_chk.sv
module clkfan_ctrl_chk
    import clkfan_pkg::*;
#(
    parameter int unsigned NUM_CLK  = CLK_LANES,
    parameter int unsigned NUM_REGS = REG_BYTES
)(
    input logic               clk,
    input logic               rst,
    input logic               scl_in,
    input logic               sda_pull,
    input logic               stop_seen,
    input logic               wr_valid,
    input logic [7:0]         wr_idx,
    input logic [NUM_CLK-1:0] en_bits
);
    // R2
    ack_on_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull) |-> !scl_in);

    // R2
    ack_off_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sda_pull) |-> !scl_in);

    // R7
    enables_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_valid |=> $stable(en_bits));

    // R5
    write_index_chk: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> (wr_idx < 8'(NUM_REGS)));

    // R11
    stop_release_chk: assert property (@(posedge clk) disable iff (rst)
        stop_seen |=> !sda_pull);

endmodule

bind clkfan_ctrl clkfan_ctrl_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .scl_in    (scl_in),
    .sda_pull  (sda_pull),
    .stop_seen (evt.stop),
    .wr_valid  (wr.valid),
    .wr_idx    (wr.idx),
    .en_bits   (en_bits)
);

// File: tb/test_clkfan_ctrl.sv
module test_clkfan_ctrl;

    localparam int NCLK = 10;
    localparam int Q    = 40;
    localparam int HALF = 80;

    logic            clk     = 1'b0;
    logic            rst     = 1'b1;
    logic            ref_clk = 1'b0;
    logic            m_scl   = 1'b1;
    logic            m_sda   = 1'b1;
    logic            oe_n    = 1'b1;
    logic            sda_pull;
    logic            sda_line;
    logic [NCLK-1:0] clk_out;
    logic [NCLK-1:0] clk_drv_en;

    int   total = 0;
    int   bad   = 0;
    bit   mon_on = 1'b0;
    bit   done   = 1'b0;
    logic [7:0] mreg [3];
    logic [7:0] tx_buf [16];

    assign sda_line = m_sda & ~sda_pull;

    always #4  clk     = ~clk;
    always #28 ref_clk = ~ref_clk;

    clkfan_ctrl i_clkfan_ctrl (
        .clk        (clk),
        .rst        (rst),
        .scl_in     (m_scl),
        .sda_in     (sda_line),
        .sda_pull   (sda_pull),
        .ref_clk    (ref_clk),
        .oe_n       (oe_n),
        .clk_out    (clk_out),
        .clk_drv_en (clk_drv_en)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [NCLK-1:0] exp_en();
        logic [NCLK-1:0] e;
        e[3:0] = mreg[0][3:0];
        e[9:6] = mreg[1][7:4];
        e[4]   = mreg[2][6];
        e[5]   = mreg[2][7];
        return e;
    endfunction

    function automatic string tag_for(int k, bit live);
        if (k == 0)  return live ? "R2" : "R3";
        if (!live && k > 12) return "R8";
        if (!live)   return "R3";
        if (k < 3)   return "R4";
        if (k < 6)   return "R5";
        return "R8";
    endfunction

    task automatic bus_start();
        m_sda = 1'b1; #Q; m_scl = 1'b1; #Q; m_sda = 1'b0; #Q; m_scl = 1'b0; #Q;
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; #Q; m_scl = 1'b1; #Q; m_sda = 1'b1; #Q;
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_sda = b[i]; #Q; m_scl = 1'b1; #HALF; m_scl = 1'b0; #Q;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        send_bits(b, 8);
        m_sda = 1'b1; #Q; m_scl = 1'b1; #Q;
        ack = !sda_line;
        #Q; m_scl = 1'b0; #Q;
    endtask

    task automatic check_outputs(input string req);
        @(posedge ref_clk); #10;
        check(clk_out == exp_en(), req, int'(clk_out), int'(exp_en()));
        @(negedge ref_clk); #10;
        check(clk_out == '0, "R6", int'(clk_out), 0);
    endtask

    // sends tx_buf[0..n-1] inside one start/stop pair and updates the model
    task automatic send_txn(input int n, input string req, input bit do_start);
        bit ack;
        bit live;
        live = 1'b1;
        if (do_start) bus_start();
        for (int k = 0; k < n; k++) begin
            send_byte(tx_buf[k], ack);
            if (k == 0)  live = (tx_buf[0] == 8'hD2);
            if (k >= 13) live = 1'b0;
            check(ack == live, tag_for(k, live), int'(ack), int'(live));
            if (live && k >= 3 && k < 6) mreg[k-3] = tx_buf[k];
        end
        bus_stop();
        check(sda_pull == 1'b0, "R11", int'(sda_pull), 0);
        #560;
        check_outputs(req);
    endtask

    // R12 and R6: constant level through every high phase, low in every low phase
    initial begin
        logic [NCLK-1:0] a;
        forever begin
            @(posedge ref_clk);
            if (mon_on) begin
                #3;  a = clk_out;
                #22; check(clk_out == a, "R12", int'(clk_out), int'(a));
                #6;  check(clk_out == '0, "R6", int'(clk_out), 0);
            end
        end
    end

    initial begin
        #1500000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        bit ack;
        int unsigned seed_dummy;
        int n;
        seed_dummy = $urandom(32'hC1F0);
        mreg[0] = 8'hFF; mreg[1] = 8'hFF; mreg[2] = 8'hC3;
        #322;
        rst = 1'b0;
        #80;
        mon_on = 1'b1;

        // R1 reset state
        check(sda_pull == 1'b0, "R1", int'(sda_pull), 0);
        check_outputs("R1");
        check(clk_drv_en == '1, "R10", int'(clk_drv_en), 10'h3FF);

        // R5 R4 mapping; header values look like data and must not land anywhere
        tx_buf[0] = 8'hD2; tx_buf[1] = 8'h00; tx_buf[2] = 8'hFF;
        tx_buf[3] = 8'h05; tx_buf[4] = 8'h30; tx_buf[5] = 8'h40;
        send_txn(6, "R5", 1'b1);

        // R7 short transfer leaves bytes 1 and 2
        tx_buf[3] = 8'h0A;
        send_txn(4, "R7", 1'b1);

        // R3 wrong and read addresses
        tx_buf[0] = 8'hD3; tx_buf[3] = 8'h00; tx_buf[4] = 8'h00; tx_buf[5] = 8'h00;
        send_txn(6, "R3", 1'b1);
        tx_buf[0] = 8'h50;
        send_txn(6, "R3", 1'b1);

        // R8 eleven data bytes: last one refused
        tx_buf[0] = 8'hD2;
        for (int k = 3; k < 14; k++) tx_buf[k] = 8'(k * 37);
        tx_buf[3] = 8'h0F; tx_buf[4] = 8'hA0; tx_buf[5] = 8'h80;
        send_txn(14, "R8", 1'b1);

        // R9 start in the middle of a data byte
        bus_start();
        send_byte(8'hD2, ack); check(ack, "R9", int'(ack), 1);
        send_byte(8'h11, ack); check(ack, "R9", int'(ack), 1);
        send_byte(8'h22, ack); check(ack, "R9", int'(ack), 1);
        send_bits(8'h00, 4);
        tx_buf[0] = 8'hD2; tx_buf[1] = 8'h00; tx_buf[2] = 8'h00; tx_buf[3] = 8'h03;
        send_txn(4, "R9", 1'b1);

        // R11 byte with no start after a stop
        send_byte(8'hD2, ack);
        check(ack == 1'b0, "R11", int'(ack), 0);
        send_byte(8'h00, ack);
        check(ack == 1'b0, "R11", int'(ack), 0);
        bus_stop();
        #560;
        check_outputs("R11");

        // R10 drive enables
        oe_n = 1'b0; #40;
        check(clk_drv_en == '0, "R10", int'(clk_drv_en), 0);
        oe_n = 1'b1; #40;
        check(clk_drv_en == '1, "R10", int'(clk_drv_en), 10'h3FF);

        // random transfers
        for (int t = 0; t < 20; t++) begin
            n = 1 + int'($urandom_range(13));
            for (int k = 0; k < 16; k++) tx_buf[k] = 8'($urandom);
            if ($urandom_range(4) != 0) tx_buf[0] = 8'hD2;
            oe_n = ($urandom_range(3) != 0);
            send_txn(n, "R5", 1'b1);
            check(clk_drv_en == {NCLK{oe_n}}, "R10", int'(clk_drv_en), int'({NCLK{oe_n}}));
        end
        oe_n = 1'b1;

        done   = 1'b1;
        mon_on = 1'b0;
        #100;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule